// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns the system clock into the two timing enables a UART needs. The first is an oversampling tick at eight times the bit rate, which the receiver uses to sample the line. The second is a bit tick once per serial bit time, which sets the width of transmitted bits and paces the receiver's bit counting. Both outputs are one-cycle enable pulses in the system clock domain. No derived clock is ever created.

Three stages run in a chain. A fixed prescaler divides the clock by 13. An 8-bit rate counter advances once per prescaler period. A 3-bit rate select then picks which counter bit paces the oversampling tick. A divide-by-8 stage counts oversampling ticks and issues the bit tick on every eighth one. A select value s gives an oversampling period of 13 × 2^(s+1) system clocks, so the bit period is 8 × 13 × 2^(s+1).

Top module: `uart_baud_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all three counters clear and both `tick_x8` and `tick_bit` are low after that edge. Counting restarts from zero when `rst_n` goes high.
- R2: With `rate_sel` held at an unsigned value s, `tick_x8` pulses once every 13 × 2^(s+1) clock cycles.
- R3: The first `tick_x8` pulse after reset release is high in the cycle that follows the 13 × 2^(s+1)-th rising edge after release. It comes one full period after reset, not half of one.
- R4: Every `tick_x8` pulse is exactly one clock cycle wide.
- R5: `tick_bit` is high only together with `tick_x8`, and on exactly every eighth `tick_x8` pulse since reset. The eighth-pulse count is kept across changes of `rate_sel`.
- R6: The first `tick_bit` pulse after reset release follows the 8 × 13 × 2^(s+1)-th rising edge.
- R7: A `tick_x8` pulse only follows a rising edge whose index since reset release is a multiple of 13. Two pulses are never closer than 26 cycles, whatever `rate_sel` does.
- R8: Let the rate count be the number of completed prescaler periods since reset, modulo 256. A `tick_x8` pulse follows the edge at which this count becomes a multiple of 2^(s+1), where s is the `rate_sel` value present at that edge. A change of `rate_sel` therefore acts from the next prescaler boundary and produces no extra pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rate_sel | input | 3 | Rate select s; oversampling period 13 × 2^(s+1) clocks |
| tick_x8 | output | 1 | One-cycle enable pulse at eight times the bit rate |
| tick_bit | output | 1 | One-cycle enable pulse once per bit time, coincident with `tick_x8` |

## Verification
The bench targets the exact cycle of the first oversampling pulse after reset. A design that detected the rising half of the selected counter bit would fire after half a period and be caught there. Select changes made just after a pulse check that the new rate takes over at the next prescaler boundary. A mux-based edge detector would emit a spurious pulse on the switch, or wait a whole old period, and either fault shows up. A cycle-by-cycle reference model checks the bit tick under random select changes and mid-run resets. An off-by-one in the divide-by-8 wrap, or a divider that clears on a select change, would misplace bit ticks.

// File: rtl/uart_baud_gen_pkg.sv
// Package: shared constants for the UART baud tick generator.
// Assumes: consumers derive every width from these values.
package uart_baud_gen_pkg;
    localparam int unsigned BG_PRESCALE_DIV = 13;
    localparam int unsigned BG_RATE_W       = 8;
    localparam int unsigned BG_SEL_W        = 3;
    localparam int unsigned BG_OVERSAMPLE   = 8;
endpackage

// File: rtl/bgen_prescaler.sv
// Module: bgen_prescaler
// Counts system clocks modulo DIV and raises a combinational strobe
// in the last cycle of each period.
// Assumes: DIV >= 2; rst_n is synchronous, active low.
module bgen_prescaler #(
    parameter int unsigned DIV = 13
) (
    input  logic clk,
    input  logic rst_n,
    output logic pre_strobe
);
    localparam int unsigned CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign pre_strobe = (cnt_q == LAST);

    // Purpose: modulo-DIV cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (pre_strobe) cnt_q <= '0;
        else                 cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/bgen_rate_tap.sv
// Module: bgen_rate_tap
// Free-running binary rate counter that advances on each prescaler strobe.
// The selected bit paces the oversampling strobe, which fires when the
// low (sel+1) bits wrap to zero. The strobe therefore lands only on
// counter increments and cannot glitch when sel changes.
// Assumes: sel is stable around the clock edge; values of sel at or
// beyond RATE_W yield no strobe.
module bgen_rate_tap #(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned SEL_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pre_strobe,
    input  logic [SEL_W-1:0] sel,
    output logic             x8_strobe
);
    localparam int unsigned SEL_SPAN = 1 << SEL_W;

    logic [RATE_W-1:0] rate_q;
    logic [RATE_W-1:0] wrap_flag;
    logic              tap;

    // Purpose: rate counter advancing once per prescaler period.
    always_ff @(posedge clk) begin
        if (!rst_n)          rate_q <= '0;
        else if (pre_strobe) rate_q <= rate_q + 1'b1;
    end

    // One flag per bit: low bits up to i are all ones, so the next increment wraps them.
    for (genvar i = 0; i < RATE_W; i++) begin : g_wrap
        assign wrap_flag[i] = &rate_q[i:0];
    end

    // Purpose: pick the wrap flag named by sel.
    always_comb begin
        tap = 1'b0;
        for (int k = 0; k < RATE_W; k++) begin
            if (k < SEL_SPAN && sel == SEL_W'(k)) tap = wrap_flag[k];
        end
    end

    assign x8_strobe = pre_strobe & tap;
endmodule

// File: rtl/bgen_oversample_div.sv
// Module: bgen_oversample_div
// Registers the oversampling strobe as a one-cycle output and counts it
// modulo OVS. The bit tick is issued on the wrap, aligned with the
// oversampling tick.
// Assumes: OVS is a power of two >= 2; rst_n is synchronous, active low.
module bgen_oversample_div #(
    parameter int unsigned OVS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic x8_strobe,
    output logic x8_tick,
    output logic bit_tick
);
    localparam int unsigned DW = $clog2(OVS);
    localparam logic [DW-1:0] LAST = DW'(OVS - 1);

    logic [DW-1:0] div_q;
    logic          x8_q;
    logic          bit_q;

    // Purpose: register both ticks and advance the eighth-pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            x8_q  <= 1'b0;
            bit_q <= 1'b0;
        end else begin
            x8_q  <= x8_strobe;
            bit_q <= x8_strobe && (div_q == LAST);
            if (x8_strobe) div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
        end
    end

    assign x8_tick  = x8_q;
    assign bit_tick = bit_q;
endmodule

// File: rtl/uart_baud_gen.sv
// Module: uart_baud_gen (top)
// Chains prescaler, selectable rate counter and divide-by-OVS stage to
// produce one-cycle oversampling and bit-time enables on the system clock.
// Assumes: single clock domain; rate_sel driven synchronously.
module uart_baud_gen
    import uart_baud_gen_pkg::*;
#(
    parameter int unsigned PRESCALE_DIV = BG_PRESCALE_DIV,
    parameter int unsigned RATE_W       = BG_RATE_W,
    parameter int unsigned SEL_W        = BG_SEL_W,
    parameter int unsigned OVERSAMPLE   = BG_OVERSAMPLE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] rate_sel,
    output logic             tick_x8,
    output logic             tick_bit
);
    logic pre_strobe;
    logic x8_strobe;

    bgen_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_strobe (pre_strobe)
    );

    bgen_rate_tap #(.RATE_W(RATE_W), .SEL_W(SEL_W)) u_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .pre_strobe (pre_strobe),
        .sel        (rate_sel),
        .x8_strobe  (x8_strobe)
    );

    bgen_oversample_div #(.OVS(OVERSAMPLE)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .x8_strobe (x8_strobe),
        .x8_tick   (tick_x8),
        .bit_tick  (tick_bit)
    );
endmodule

// File: rtl/uart_baud_gen_chk.sv
// Module: uart_baud_gen_chk
// Port-level checker for uart_baud_gen, bound to every instance.
// Assumes: default prescale 13, oversampling 8, minimum period 26 cycles.
module uart_baud_gen_chk #(
    parameter int unsigned SEL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SEL_W-1:0] rate_sel,
    input logic             tick_x8,
    input logic             tick_bit
);
    logic [3:0] phase_q;
    logic [7:0] gap_q;
    logic [2:0] seen_q;

    // Purpose: track phase modulo 13 since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n)               phase_q <= '0;
        else if (phase_q == 4'd12) phase_q <= '0;
        else                      phase_q <= phase_q + 1'b1;
    end

    // Purpose: cycles since last oversampling pulse, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_q <= '0;
        else if (tick_x8)        gap_q <= 8'd1;
        else if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
    end

    // Purpose: oversampling pulses seen since the last bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                    seen_q <= '0;
        else if (tick_x8 && tick_bit)  seen_q <= '0;
        else if (tick_x8)              seen_q <= seen_q + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tick_x8 && !tick_bit));

    p_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick_x8 |=> !tick_x8);

    p_bit_on_x8_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_bit |-> tick_x8);

    p_eighth_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_x8 |-> (tick_bit == (seen_q == 3'd7)));

    p_grid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_x8 |-> (phase_q == 4'd0));

    p_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_x8 |-> (gap_q >= 8'd26));
endmodule

bind uart_baud_gen uart_baud_gen_chk #(.SEL_W(SEL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate_sel (rate_sel),
    .tick_x8  (tick_x8),
    .tick_bit (tick_bit)
);

// File: tb/sim_uart_baud_gen.sv
`timescale 1ns/1ps
module sim_uart_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] rate_sel = 3'd0;
    logic       tick_x8, tick_bit;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;

    // Reference model state.
    int unsigned edge_n = 0;
    logic        exp_x8 = 1'b0, exp_bit = 1'b0;
    logic [2:0]  x8_count = '0;

    uart_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
        .tick_x8(tick_x8), .tick_bit(tick_bit)
    );

    always #5 clk = ~clk;

    function automatic int unsigned period_of(input int unsigned s);
        return 13 * (2 << s);
    endfunction

    function automatic logic x8_due(input int unsigned n, input int unsigned s);
        return (n % 13 == 0) && (n != 0) && (((n / 13) % (2 << s)) == 0);
    endfunction

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model update at each edge; inputs change only at negedge.
    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n <= 0; exp_x8 <= 0; exp_bit <= 0; x8_count <= 0;
        end else begin
            edge_n <= edge_n + 1;
            if (x8_due(edge_n + 1, rate_sel)) begin
                exp_x8   <= 1'b1;
                exp_bit  <= (x8_count == 3'd7);
                x8_count <= x8_count + 1'b1;
            end else begin
                exp_x8  <= 1'b0;
                exp_bit <= 1'b0;
            end
        end
    end

    // Cycle-by-cycle comparison (R2 R8 for the 8x tick, R5 for the bit tick).
    always @(negedge clk) begin
        if (rst_n) begin
            check(tick_x8 === exp_x8, "R2 R8 tick_x8 model", int'(tick_x8), int'(exp_x8));
            check(tick_bit === exp_bit, "R5 tick_bit model", int'(tick_bit), int'(exp_bit));
        end
    end

    task automatic do_reset(input int unsigned cyc);
        @(negedge clk); rst_n = 1'b0;
        repeat (cyc) @(negedge clk);
        check(tick_x8 === 1'b0 && tick_bit === 1'b0, "R1 outputs low in reset",
              int'({tick_x8, tick_bit}), 0);
        rst_n = 1'b1;
    endtask

    // Count negedges after release until the signal is seen high.
    task automatic wait_x8(output int unsigned cnt);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!tick_x8 && cnt < 40000);
    endtask

    task automatic wait_bit(output int unsigned cnt);
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!tick_bit && cnt < 40000);
    endtask

    task automatic directed_rate(input int unsigned s);
        int unsigned c;
        rate_sel = 3'(s);
        do_reset(3);
        wait_x8(c);
        check(c == period_of(s), "R3 first tick_x8 cycle", int'(c), int'(period_of(s)));
        @(negedge clk);
        check(tick_x8 === 1'b0, "R4 tick_x8 one cycle wide", int'(tick_x8), 0);
        wait_x8(c);
        check(c == period_of(s) - 1, "R2 steady period", int'(c + 1), int'(period_of(s)));
        rate_sel = 3'(s);
        do_reset(2);
        wait_bit(c);
        check(c == 8 * period_of(s), "R6 first tick_bit cycle", int'(c), int'(8 * period_of(s)));
        check(tick_x8 === 1'b1, "R5 tick_bit coincides with tick_x8", int'(tick_x8), 1);
    endtask

    initial begin
        int unsigned c;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        check(tick_x8 === 1'b0 && tick_bit === 1'b0, "R1 reset state",
              int'({tick_x8, tick_bit}), 0);

        for (int s = 0; s < 4; s++) directed_rate(s);
        directed_rate(7);

        // R8: switch from select 3 to 0 right after a pulse at rate count 16.
        rate_sel = 3'd3;
        do_reset(2);
        wait_x8(c);
        rate_sel = 3'd0;
        wait_x8(c);
        check(c == 26, "R8 R7 new select takes over at next boundary", int'(c), 26);

        // R8: switch from 0 to 2 right after a pulse at count 2; next at count 8.
        do_reset(2);
        wait_x8(c);
        rate_sel = 3'd2;
        wait_x8(c);
        check(c == 78, "R8 switch to slower rate", int'(c), 78);

        // Random select changes and mid-run resets, checked by the model.
        for (int k = 0; k < 60; k++) begin
            int unsigned hold = 1 + ($urandom % 600);
            if ($urandom % 10 == 0) do_reset(1 + $urandom % 4);
            repeat (hold) @(negedge clk);
            rate_sel = 3'($urandom % 8);
        end
        repeat (3000) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(10ns * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule